// File: doc/BRIEF.md
# Mode-Configurable BCH Syndrome Calculator

This block computes the syndromes of a binary BCH codeword read back from a flash page. The codeword streams in as 8-bit slices, one slice per valid cycle, highest-degree coefficient first. Three correction strengths share one datapath, and the strength is chosen per frame at run time: t=32 over an 8640-bit codeword, t=16 over 8416 bits and t=8 over 8304 bits. All three carry 8192 data bits. Arithmetic is in GF(2^14), so the parity part is 14·t bits long.

Each odd syndrome has its own remainder unit. The unit divides the incoming polynomial by the minimal polynomial of the matching field root, 8 division steps per cycle. At the end of the frame the 14-bit remainder is evaluated at that root. Even syndromes are not computed separately. Each is obtained by repeated squaring of the odd syndrome it descends from. Remainder units that the selected strength does not need get no clock enable, so their registers do not toggle.

When a frame ends the block presents all 2t syndromes at once, together with a one-cycle done pulse and a flag that is set when every syndrome is zero. A later decoding stage can use that flag to skip error location entirely.

Top module: `bchs_syndrome`

## Requirements
- R1: `cfg_mode` selects the strength: 2'b01 gives t=16 (1052 beats), 2'b10 gives t=8 (1038 beats), and 2'b00 or 2'b11 give t=32 (1080 beats). A frame is exactly that many accepted beats.
- R2: The first accepted beat carries the highest-degree coefficients. Inside a beat, `in_data[7]` is the higher-degree bit and `in_data[0]` the lower.
- R3: For odd j ≤ 2t, syndrome S_j equals r(α^j). Here α is a root of x^14+x^10+x^6+x+1, written as 14'h0002, and bit k of a field element is the coefficient of α^k.
- R4: For even j ≤ 2t, S_j equals (S_{j/2})^2.
- R5: `synd_out[(j-1)*14 +: 14]` holds S_j for j from 1 to 64. Every S_j with j > 2t reads zero.
- R6: `synd_done` is high for exactly one cycle. It rises two clock edges after the edge that accepts the last beat. `synd_out` and `synd_zero` change only together with `synd_done` and then hold until the next done.
- R7: `synd_zero` is high with `synd_done` exactly when every reported syndrome is zero.
- R8: `cfg_mode` is sampled only on an accepted `frame_start`. Changes during a frame have no effect.
- R9: `frame_start` is accepted only when no frame is in progress. Beats with `in_valid` high outside a frame are ignored, including the beat in the start cycle. Cycles with `in_valid` low inside a frame stall the frame without altering it.
- R10: Remainder units for odd indices above 2t keep their register values throughout a frame. Because of this, a lower-strength frame reports zero above 2t even when it follows a full-strength frame.
- R11: After reset `synd_done` and `synd_zero` are low and `synd_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Strength select, sampled on an accepted start |
| frame_start | input | 1 | Begins a frame when idle |
| in_valid | input | 1 | Qualifies `in_data` |
| in_data | input | 8 | Codeword slice, bit 7 the higher degree |
| synd_done | output | 1 | One-cycle pulse, syndromes ready |
| synd_zero | output | 1 | All syndromes zero |
| synd_out | output | 896 | S_1..S_64, 14 bits each, S_1 in the low bits |

## Verification
The hardest case to reach from the ports is a frame that is disturbed while it runs. In that case `cfg_mode` flips and a second `frame_start` arrives mid-stream, and the result must still follow the strength latched at the real start. The stimulus produces this by toggling both inputs halfway through a t=16 frame, inserting random idle gaps into the beat stream, and feeding junk beats before a start. A second hard case is state left behind by a previous frame. A full t=32 frame is run first and a t=8 frame straight after, so the upper syndromes of the second result expose any leak. Single error bits at the lowest and highest codeword positions pin the ordering of beats and bits.

// File: rtl/bchs_pkg.sv
package bchs_pkg;

   localparam int GF_M = 14;
   localparam logic [GF_M:0] GF_POLY = 15'h4443;
   localparam int GF_N = (1 << GF_M) - 1;

   typedef logic [GF_M-1:0] gf_t;

   typedef enum logic [1:0] {
      LVL_HI  = 2'd0,
      LVL_MID = 2'd1,
      LVL_LO  = 2'd2
   } lvl_e;

   function automatic gf_t gf_mul(input gf_t a, input gf_t b);
      gf_t acc;
      gf_t sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < GF_M; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = sh[GF_M-1] ? ((sh << 1) ^ GF_POLY[GF_M-1:0]) : (sh << 1);
      end
      return acc;
   endfunction

   function automatic gf_t gf_sq_n(input gf_t x, input int n);
      gf_t v;
      v = x;
      for (int i = 0; i < n; i++) v = gf_mul(v, v);
      return v;
   endfunction

   function automatic gf_t alpha_pow(input int e);
      gf_t acc;
      gf_t base;
      int  r;
      r    = e % GF_N;
      acc  = gf_t'(1);
      base = gf_t'(2);
      for (int i = 0; i < GF_M; i++) begin
         if (((r >> i) & 1) == 1) acc = gf_mul(acc, base);
         base = gf_mul(base, base);
      end
      return acc;
   endfunction

   function automatic logic [GF_M:0] min_poly(input int idx);
      gf_t c [GF_M+1];
      gf_t beta;
      logic [GF_M:0] res;
      int e;
      for (int k = 0; k <= GF_M; k++) c[k] = '0;
      c[0] = gf_t'(1);
      e = idx % GF_N;
      for (int j = 0; j < GF_M; j++) begin
         beta = alpha_pow(e);
         for (int k = GF_M; k > 0; k--) c[k] = c[k-1] ^ gf_mul(c[k], beta);
         c[0] = gf_mul(c[0], beta);
         e = (e * 2) % GF_N;
      end
      for (int k = 0; k <= GF_M; k++) res[k] = c[k][0];
      return res;
   endfunction

   function automatic int odd_part(input int v);
      int x;
      x = v;
      while ((x % 2) == 0) x = x / 2;
      return x;
   endfunction

   function automatic int twos_count(input int v);
      int x;
      int n;
      x = v;
      n = 0;
      while ((x % 2) == 0) begin
         x = x / 2;
         n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/bchs_frame_ctrl.sv
module bchs_frame_ctrl
   import bchs_pkg::*;
#(
   parameter int BEATS_HI  = 1080,
   parameter int BEATS_MID = 1052,
   parameter int BEATS_LO  = 1038,
   parameter int CNT_W     = 11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cfg_mode,
   input  logic       frame_start,
   input  logic       in_valid,
   output logic       clr,
   output logic       beat_en,
   output logic       eval_en,
   output logic       busy,
   output lvl_e       lvl
);

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_EVAL = 2'd2
   } st_e;

   st_e              st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_cnt;

   if (BEATS_HI >= (1 << CNT_W)) begin : g_bad_cnt
      $error("bchs_frame_ctrl: CNT_W too small for BEATS_HI");
   end

   function automatic lvl_e decode(input logic [1:0] m);
      case (m)
         2'b01:   return LVL_MID;
         2'b10:   return LVL_LO;
         default: return LVL_HI;
      endcase
   endfunction

   always_comb begin
      case (lvl)
         LVL_MID: last_cnt = CNT_W'(BEATS_MID - 1);
         LVL_LO:  last_cnt = CNT_W'(BEATS_LO - 1);
         default: last_cnt = CNT_W'(BEATS_HI - 1);
      endcase
   end

   assign clr     = (st == ST_IDLE) && frame_start;
   assign beat_en = (st == ST_RUN) && in_valid;
   assign eval_en = (st == ST_EVAL);
   assign busy    = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
         lvl <= LVL_HI;
      end else begin
         case (st)
            ST_IDLE: begin
               if (frame_start) begin
                  lvl <= decode(cfg_mode);
                  cnt <= '0;
                  st  <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (in_valid) begin
                  cnt <= cnt + 1'b1;
                  if (cnt == last_cnt) st <= ST_EVAL;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bchs_rem_unit.sv
module bchs_rem_unit
   import bchs_pkg::*;
#(
   parameter int            BEAT  = 8,
   parameter logic [GF_M:0] MPOLY = GF_POLY
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            en,
   input  logic [BEAT-1:0] din,
   output gf_t             rem
);

   gf_t  nxt;
   logic fb;

   if (MPOLY[GF_M] != 1'b1 || MPOLY[0] != 1'b1) begin : g_bad_poly
      $error("bchs_rem_unit: divisor must be monic of full degree with nonzero constant");
   end

   always_comb begin
      nxt = rem;
      fb  = 1'b0;
      for (int b = BEAT - 1; b >= 0; b--) begin
         fb  = nxt[GF_M-1];
         nxt = {nxt[GF_M-2:0], din[b]} ^ (fb ? MPOLY[GF_M-1:0] : gf_t'(0));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rem <= '0;
      else if (clr) rem <= '0;
      else if (en)  rem <= nxt;
   end

endmodule

// File: rtl/bchs_root_eval.sv
module bchs_root_eval
   import bchs_pkg::*;
#(
   parameter int IDX = 1
) (
   input  gf_t rem,
   output gf_t val
);

   gf_t term [GF_M];

   for (genvar k = 0; k < GF_M; k++) begin : g_term
      localparam gf_t W = alpha_pow(IDX * k);
      assign term[k] = rem[k] ? W : gf_t'(0);
   end

   always_comb begin
      val = '0;
      for (int k = 0; k < GF_M; k++) val = val ^ term[k];
   end

endmodule

// File: rtl/bchs_syndrome.sv
module bchs_syndrome
   import bchs_pkg::*;
#(
   parameter int T_HI   = 32,
   parameter int T_MID  = 16,
   parameter int T_LO   = 8,
   parameter int K_BITS = 8192,
   parameter int BEAT   = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               cfg_mode,
   input  logic                     frame_start,
   input  logic                     in_valid,
   input  logic [BEAT-1:0]          in_data,
   output logic                     synd_done,
   output logic                     synd_zero,
   output logic [2*T_HI*GF_M-1:0]   synd_out
);

   localparam int N_ODD     = T_HI;
   localparam int N_SYN     = 2 * T_HI;
   localparam int BEATS_HI  = (K_BITS + GF_M * T_HI)  / BEAT;
   localparam int BEATS_MID = (K_BITS + GF_M * T_MID) / BEAT;
   localparam int BEATS_LO  = (K_BITS + GF_M * T_LO)  / BEAT;
   localparam int CNT_W     = $clog2(BEATS_HI + 1);

   if (!(T_HI > T_MID && T_MID > T_LO && T_LO > 0)) begin : g_bad_t
      $error("bchs_syndrome: strengths must be strictly decreasing and positive");
   end
   if (((K_BITS + GF_M * T_HI) % BEAT) != 0 ||
       ((K_BITS + GF_M * T_MID) % BEAT) != 0 ||
       ((K_BITS + GF_M * T_LO) % BEAT) != 0) begin : g_bad_beat
      $error("bchs_syndrome: codeword lengths must be whole beats");
   end
   if (2 * T_HI >= GF_N) begin : g_bad_field
      $error("bchs_syndrome: too many syndromes for the field");
   end

   logic clr;
   logic beat_en;
   logic eval_en;
   logic busy;
   lvl_e lvl;
   int   t_act;

   logic [N_ODD-1:0]            unit_on;
   logic [N_ODD-1:0][GF_M-1:0]  rem_bus;
   logic [N_ODD-1:0][GF_M-1:0]  odd_val;
   logic [N_ODD-1:0][GF_M-1:0]  odd_m;
   logic [N_SYN-1:0][GF_M-1:0]  syn_next;
   logic [N_SYN-1:0][GF_M-1:0]  syn_q;
   logic                        done_q;
   logic                        zero_q;

   bchs_frame_ctrl #(
      .BEATS_HI  (BEATS_HI),
      .BEATS_MID (BEATS_MID),
      .BEATS_LO  (BEATS_LO),
      .CNT_W     (CNT_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_mode    (cfg_mode),
      .frame_start (frame_start),
      .in_valid    (in_valid),
      .clr         (clr),
      .beat_en     (beat_en),
      .eval_en     (eval_en),
      .busy        (busy),
      .lvl         (lvl)
   );

   always_comb begin
      case (lvl)
         LVL_MID: t_act = T_MID;
         LVL_LO:  t_act = T_LO;
         default: t_act = T_HI;
      endcase
   end

   for (genvar u = 0; u < N_ODD; u++) begin : g_unit
      localparam int IDX = 2 * u + 1;

      assign unit_on[u] = (u < t_act);

      bchs_rem_unit #(
         .BEAT  (BEAT),
         .MPOLY (min_poly(IDX))
      ) u_rem (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .en    (beat_en & unit_on[u]),
         .din   (in_data),
         .rem   (rem_bus[u])
      );

      bchs_root_eval #(
         .IDX (IDX)
      ) u_eval (
         .rem (rem_bus[u]),
         .val (odd_val[u])
      );

      assign odd_m[u] = unit_on[u] ? odd_val[u] : gf_t'(0);
   end

   for (genvar s = 1; s <= N_SYN; s++) begin : g_syn
      localparam int OP = odd_part(s);
      localparam int SQ = twos_count(s);
      assign syn_next[s-1] = (s <= 2 * t_act) ? gf_sq_n(odd_val[(OP-1)/2], SQ) : gf_t'(0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         syn_q  <= '0;
         zero_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= eval_en;
         if (eval_en) begin
            syn_q  <= syn_next;
            zero_q <= (odd_m == '0);
         end
      end
   end

   assign synd_done = done_q;
   assign synd_zero = zero_q;
   assign synd_out  = syn_q;

endmodule

// File: rtl/bchs_syndrome_chk.sv
module bchs_syndrome_chk
   import bchs_pkg::*;
#(
   parameter int N_ODD = 32,
   parameter int T_MID = 16,
   parameter int T_LO  = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        synd_done,
   input logic                        synd_zero,
   input logic [2*N_ODD*GF_M-1:0]     synd_out,
   input lvl_e                        lvl,
   input logic                        busy,
   input logic                        clr,
   input logic [N_ODD-1:0]            unit_on,
   input logic [N_ODD-1:0][GF_M-1:0]  rem_bus
);

   localparam int TOP_BIT = 2 * N_ODD * GF_M - 1;
   localparam int MID_LSB = 2 * T_MID * GF_M;
   localparam int LO_LSB  = 2 * T_LO * GF_M;

   logic [N_ODD-1:0][GF_M-1:0] off_mask;

   always_comb begin
      for (int u = 0; u < N_ODD; u++) off_mask[u] = unit_on[u] ? gf_t'(0) : '1;
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      synd_done |=> !synd_done); // R6

   AST_OUT_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(synd_out) |-> synd_done); // R6

   AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      synd_done |-> (synd_zero == (synd_out == '0))); // R7

   AST_LO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (synd_done && lvl == LVL_LO) |-> (synd_out[TOP_BIT:LO_LSB] == '0)); // R5

   AST_MID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (synd_done && lvl == LVL_MID) |-> (synd_out[TOP_BIT:MID_LSB] == '0)); // R5

   AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(lvl)); // R8

   AST_IDLE_UNITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr) |-> (((rem_bus ^ $past(rem_bus)) & off_mask) == '0)); // R10

endmodule

bind bchs_syndrome bchs_syndrome_chk #(
   .N_ODD (T_HI),
   .T_MID (T_MID),
   .T_LO  (T_LO)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .synd_done (synd_done),
   .synd_zero (synd_zero),
   .synd_out  (synd_out),
   .lvl       (lvl),
   .busy      (busy),
   .clr       (clr),
   .unit_on   (unit_on),
   .rem_bus   (rem_bus)
);

// File: tb/sim_bchs_syndrome.sv
module sim_bchs_syndrome;

   localparam int CLK_PERIOD = 10;
   localparam int FM   = 14;
   localparam int NSYN = 64;
   localparam int OW   = NSYN * FM;

   typedef struct {
      logic [OW-1:0] syn;
      logic          zero;
      int            t;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_mode = 2'b00;
   logic          frame_start = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_data = 8'h00;
   logic          synd_done;
   logic          synd_zero;
   logic [OW-1:0] synd_out;

   int   n_cmp = 0;
   int   n_bad = 0;
   exp_t sb [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   bchs_syndrome u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_mode    (cfg_mode),
      .frame_start (frame_start),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .synd_done   (synd_done),
      .synd_zero   (synd_zero),
      .synd_out    (synd_out)
   );

   function automatic logic [13:0] fmul(input logic [13:0] a, input logic [13:0] b);
      logic [26:0] p;
      p = '0;
      for (int i = 0; i < 14; i++) if (b[i]) p = p ^ (27'(a) << i);
      for (int k = 26; k >= 14; k--) if (p[k]) p = p ^ (27'h4443 << (k - 14));
      return p[13:0];
   endfunction

   function automatic int t_of(input logic [1:0] m);
      return (m == 2'b01) ? 16 : ((m == 2'b10) ? 8 : 32);
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   // kind: 0 all zero, 1 random, 2 one bit at x^0, 3 one bit at x^(n-1)
   task automatic run_frame(input logic [1:0] mode, input int kind,
                            input bit gaps, input bit disturb);
      logic [7:0]  fr [$];
      logic [13:0] aj [NSYN+1];
      logic [13:0] sj [NSYN+1];
      exp_t        e;
      int          t;
      int          nb;
      t  = t_of(mode);
      nb = (8192 + 14 * t) / 8;
      for (int i = 0; i < nb; i++) fr.push_back((kind == 1) ? 8'($urandom) : 8'h00);
      if (kind == 2) fr[nb-1][0] = 1'b1;
      if (kind == 3) fr[0][7] = 1'b1;
      aj[0] = 14'd1;
      for (int j = 1; j <= NSYN; j++) aj[j] = fmul(aj[j-1], 14'd2);
      for (int j = 0; j <= NSYN; j++) sj[j] = '0;
      for (int i = 0; i < nb; i++) begin
         for (int b = 7; b >= 0; b--) begin
            for (int j = 1; j <= 2 * t; j++) sj[j] = fmul(sj[j], aj[j]) ^ {13'd0, fr[i][b]};
         end
      end
      e.syn  = '0;
      e.zero = 1'b1;
      e.t    = t;
      for (int j = 1; j <= 2 * t; j++) begin
         e.syn[(j-1)*FM +: FM] = sj[j];
         if (sj[j] != 0) e.zero = 1'b0;
      end
      sb.push_back(e);

      @(negedge clk);
      cfg_mode    = mode;
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      for (int i = 0; i < nb; i++) begin
         if (gaps && ($urandom % 4 == 0)) begin
            in_valid = 1'b0;
            in_data  = 8'($urandom);
            @(negedge clk);
         end
         in_valid = 1'b1;
         in_data  = fr[i];
         if (disturb && i == nb / 2) begin
            cfg_mode    = mode ^ 2'b11;
            frame_start = 1'b1;
         end else begin
            frame_start = 1'b0;
         end
         @(negedge clk);
      end
      in_valid    = 1'b0;
      in_data     = 8'h00;
      frame_start = 1'b0;
      @(negedge clk);
      check(synd_done == 1'b1, "R1 R6", "done two edges after final beat", 64'(synd_done), 64'd1);
      @(negedge clk);
      check(synd_done == 1'b0, "R6", "done lasts one cycle", 64'(synd_done), 64'd0);
   endtask

   // scoreboard monitor
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (rst_n && synd_done) begin
            if (sb.size() == 0) begin
               check(1'b0, "R6", "done without a pending frame", 64'd1, 64'd0);
            end else begin
               int bad_odd;
               int bad_even;
               int bad_up;
               e = sb.pop_front();
               bad_odd = 0;
               bad_even = 0;
               bad_up = 0;
               for (int j = NSYN; j >= 1; j--) begin
                  if (synd_out[(j-1)*FM +: FM] !== e.syn[(j-1)*FM +: FM]) begin
                     if (j > 2 * e.t)        bad_up = j;
                     else if ((j % 2) == 1)  bad_odd = j;
                     else                    bad_even = j;
                  end
               end
               check(bad_odd == 0, "R3 R2", $sformatf("odd syndrome S%0d (t=%0d)", bad_odd, e.t),
                     (bad_odd == 0) ? 64'd0 : 64'(synd_out[(bad_odd-1)*FM +: FM]),
                     (bad_odd == 0) ? 64'd0 : 64'(e.syn[(bad_odd-1)*FM +: FM]));
               check(bad_even == 0, "R4", $sformatf("even syndrome S%0d (t=%0d)", bad_even, e.t),
                     (bad_even == 0) ? 64'd0 : 64'(synd_out[(bad_even-1)*FM +: FM]),
                     (bad_even == 0) ? 64'd0 : 64'(e.syn[(bad_even-1)*FM +: FM]));
               if (e.t < 32) begin
                  check(bad_up == 0, "R5 R10", $sformatf("upper syndrome S%0d (t=%0d)", bad_up, e.t),
                        (bad_up == 0) ? 64'd0 : 64'(synd_out[(bad_up-1)*FM +: FM]), 64'd0);
               end
               check(synd_zero == e.zero, "R7", "all-zero flag", 64'(synd_zero), 64'(e.zero));
            end
         end
      end
   end

   // watchdog
   initial begin
      #(CLK_PERIOD * 190000);
      n_cmp++;
      n_bad++;
      $display("FAIL R6 watchdog: pending results actual %0d expected %0d", sb.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(synd_done == 1'b0, "R11", "done after reset", 64'(synd_done), 64'd0);
      check(synd_zero == 1'b0, "R11", "zero flag after reset", 64'(synd_zero), 64'd0);
      check(synd_out == '0, "R11", "syndromes after reset", 64'(synd_out[63:0]), 64'd0);

      // R9: junk beats while idle must not reach the next frame
      for (int i = 0; i < 16; i++) begin
         in_valid = 1'b1;
         in_data  = 8'($urandom) | 8'h01;
         @(negedge clk);
      end
      in_data = 8'hFF;
      run_frame(2'b10, 0, 1'b0, 1'b0);   // R7 R9 zero frame, t=8
      run_frame(2'b10, 1, 1'b0, 1'b0);   // R3 R4 random, t=8
      run_frame(2'b01, 1, 1'b1, 1'b0);   // R9 stalls, t=16
      run_frame(2'b00, 1, 1'b0, 1'b0);   // R1 full strength
      run_frame(2'b10, 1, 1'b1, 1'b0);   // R10 after full strength
      run_frame(2'b00, 2, 1'b0, 1'b0);   // R2 lowest position
      run_frame(2'b00, 3, 1'b0, 1'b0);   // R2 highest position
      run_frame(2'b01, 1, 1'b1, 1'b1);   // R8 R9 mode flip and start mid-frame
      run_frame(2'b11, 1, 1'b0, 1'b0);   // R1 code 3 is t=32
      run_frame(2'b01, 0, 1'b0, 1'b0);   // R7 zero frame, t=16
      run_frame(2'b10, 3, 1'b0, 1'b0);   // R2 R5 highest position, t=8

      repeat (4) @(negedge clk);
      check(sb.size() == 0, "R6", "every frame reported", 64'(sb.size()), 64'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule